// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the device side of an 8-bit NAND flash bus. It sorts each write strobe into a command, address or data cycle using the two latch qualifiers. It keeps a 528-byte page buffer, which is 512 main bytes followed by 16 spare bytes, and commits that buffer into a small behavioural cell array that holds a few pages. A controller runs a program as a fixed sequence: the load opcode, three address cycles, one or more data bytes, then the confirm opcode. The sequencer then reports busy for a fixed number of cycles.

The sequencer enforces the protocol:
- A confirm that has no data behind it is dropped.
- While busy, only status and reset opcodes are honoured.
- Each page has two partial-program budgets, one for the main area and one for the spare area. An attempt beyond either budget is refused and the fail flag is set.

After the status opcode, every read strobe returns the status byte until another opcode is accepted. The spare-read opcode fetches the spare area of a page and streams it out one byte per read strobe.

Top module: `nand_cmd_if`

## Requirements
- R1: The load opcode 80h is followed by three address cycles: column, page, then an ignored high row byte. Data cycles then fill the page buffer at consecutive columns from the start column. In main mode the start column is the column byte. In spare mode it is 512 plus the column byte's bits [3:0]. The buffer is filled with FFh when 80h is accepted.
- R2: The confirm opcode 10h is ignored unless 80h, its three address cycles and at least one data byte have been received.
- R3: While busy_o is high, every opcode other than 70h and FFh is ignored, and so are address and data cycles.
- R4: The status byte has bit 6 = 1 when ready and 0 when busy, and bit 0 = 1 when the last program attempt failed. All other bits are 0.
- R5: After 70h, each read strobe returns the status byte until another opcode is accepted.
- R6: An accepted confirm raises busy_o on the next cycle and holds it for PROG_CYCLES cycles.
- R7: Programming ANDs the buffer into the stored page, so bits only go from 1 to 0. A byte that asks for 1 over a stored 0 reads back 0 and does not set the fail bit.
- R8: The spare-read opcode 50h followed by three address cycles holds busy_o for READ_CYCLES cycles. Read strobes then return spare bytes in sequence from 512 plus the column's bits [3:0], with bits [7:4] ignored, and FFh once past column 527.
- R9: Each page allows MAIN_PP_MAX (2) programs that touch the main area and SPARE_PP_MAX (3) that touch the spare area, counted separately. A further attempt sets the fail bit, leaves the array unchanged and still holds busy for PROG_CYCLES.
- R10: FFh is accepted at any time. It ends any load or read sequence, clears the fail bit, status mode and spare selection, and holds busy_o for RST_CYCLES cycles, which replaces any program time still remaining.
- R11: Asynchronous reset clears busy_o and data_o to 0, erases every cell to FFh and zeroes the partial-program counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | Bus write cycle strobe, one clock per cycle |
| cmd_latch_i | input | 1 | Qualifies a write cycle as a command |
| addr_latch_i | input | 1 | Qualifies a write cycle as an address |
| data_i | input | 8 | Write-cycle byte |
| rd_stb_i | input | 1 | Read cycle strobe; data_o updates at this edge |
| data_o | output | 8 | Read-cycle byte (status or spare data) |
| busy_o | output | 1 | High while a program, read or reset is in progress |

## Verification
The bench builds the block with two pages, a 20-cycle program time, a 5-cycle read time and a 3-cycle reset time. These short times let many complete program-and-read-back sequences fit in one run. They also keep a reset issued in the middle of a program observably shorter than the program itself, and status bytes taken during busy are still reachable. Two pages are enough to show that the main and spare budgets are counted per page and per area. They also show that exhausting one area leaves the other free.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_CONFIRM  = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_SPARE_RD = 8'h50;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  localparam int STS_READY_BIT = 6;
  localparam int STS_FAIL_BIT  = 0;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PADDR,
    SQ_PLOAD,
    SQ_RADDR,
    SQ_RDATA
  } seq_state_e;
endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          busy_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q > TW'(1)) |=> busy_o); // R6
endmodule

// File: rtl/nand_pp_limit.sv
module nand_pp_limit #(
  parameter int NUM_PAGES    = 2,
  parameter int PW           = 1,
  parameter int MAIN_PP_MAX  = 2,
  parameter int SPARE_PP_MAX = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] page_i,
  input  logic          use_main_i,
  input  logic          use_spare_i,
  input  logic          commit_i,
  output logic          ok_o
);
  localparam int PP_TOP = (MAIN_PP_MAX > SPARE_PP_MAX) ? MAIN_PP_MAX : SPARE_PP_MAX;
  localparam int KW     = $clog2(PP_TOP + 1);

  logic [KW-1:0] main_q  [NUM_PAGES];
  logic [KW-1:0] spare_q [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pg
    logic hit;
    assign hit = commit_i && (page_i == PW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        main_q[g]  <= '0;
        spare_q[g] <= '0;
      end else if (hit) begin
        if (use_main_i)  main_q[g]  <= main_q[g] + 1'b1;
        if (use_spare_i) spare_q[g] <= spare_q[g] + 1'b1;
      end
    end

    AST_MAIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      main_q[g] <= KW'(MAIN_PP_MAX)); // R9
    AST_SPARE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      spare_q[g] <= KW'(SPARE_PP_MAX)); // R9
  end

  assign ok_o = (!use_main_i  || main_q[page_i]  < KW'(MAIN_PP_MAX)) &&
                (!use_spare_i || spare_q[page_i] < KW'(SPARE_PP_MAX));
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int NUM_PAGES  = 2,
  parameter int PAGE_BYTES = 528,
  parameter int CW         = 10,
  parameter int PW         = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_col_i,
  input  logic [7:0]    wr_data_i,
  input  logic          commit_i,
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] rd_page_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [7:0]    rd_data_o
);
  localparam int DEPTH = NUM_PAGES * PAGE_BYTES;
  localparam int MW    = $clog2(DEPTH);

  logic [7:0]    preg_q [PAGE_BYTES];
  logic [7:0]    mem_q  [DEPTH];
  logic [MW-1:0] wr_base, rd_idx;

  assign wr_base = MW'(page_i) * MW'(PAGE_BYTES);
  assign rd_idx  = MW'(rd_page_i) * MW'(PAGE_BYTES) + MW'(rd_col_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) preg_q[i] <= 8'hFF;
    end else if (clr_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) preg_q[i] <= 8'hFF;
    end else if (wr_i && wr_col_i < CW'(PAGE_BYTES)) begin
      preg_q[wr_col_i] <= wr_data_i;
    end
  end

  // cells only ever lose ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem_q[wr_base + MW'(i)] <= mem_q[wr_base + MW'(i)] & preg_q[i];
    end
  end

  assign rd_data_o = (rd_col_i < CW'(PAGE_BYTES)) ? mem_q[rd_idx] : 8'hFF;

  AST_COMMIT_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && page_i == rd_page_i && rd_col_i < CW'(PAGE_BYTES))
      |=> (rd_data_o & ~$past(rd_data_o)) == 8'h00); // R7
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_cmd_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int PAGE_BYTES  = 528,
  parameter int CW          = 10,
  parameter int PW          = 1,
  parameter int SW          = 4,
  parameter int TW          = 16,
  parameter int PROG_CYCLES = 20,
  parameter int READ_CYCLES = 5,
  parameter int RST_CYCLES  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic          cmd_latch_i,
  input  logic          addr_latch_i,
  input  logic [7:0]    data_i,
  input  logic          rd_stb_i,
  input  logic          busy_i,
  input  logic          ok_i,
  input  logic [7:0]    rd_data_i,
  output logic          reg_clr_o,
  output logic          reg_wr_o,
  output logic [CW-1:0] reg_col_o,
  output logic [7:0]    reg_data_o,
  output logic          commit_o,
  output logic [PW-1:0] page_o,
  output logic          use_main_o,
  output logic          use_spare_o,
  output logic [PW-1:0] rd_page_o,
  output logic [CW-1:0] rd_col_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic [7:0]    data_o
);
  seq_state_e    st_q;
  logic [1:0]    adr_cnt_q;
  logic [CW-1:0] col_q, ptr_q;
  logic [PW-1:0] page_q;
  logic          spare_q, stat_q, fail_q, got_main_q, got_spare_q;
  logic [7:0]    dout_q;

  logic cmd_v, adr_v, dat_v;
  logic op_rst, op_load, op_spare, confirm_ok, adr_ok, last_adr;
  logic [CW-1:0] col_new;
  logic [7:0]    sts;

  assign cmd_v = wr_stb_i &  cmd_latch_i & ~addr_latch_i;
  assign adr_v = wr_stb_i & ~cmd_latch_i &  addr_latch_i;
  assign dat_v = wr_stb_i & ~cmd_latch_i & ~addr_latch_i;

  assign op_rst     = cmd_v && data_i == OP_RESET;
  assign op_load    = cmd_v && data_i == OP_LOAD && !busy_i;
  assign op_spare   = cmd_v && data_i == OP_SPARE_RD && !busy_i;
  assign confirm_ok = cmd_v && data_i == OP_CONFIRM && !busy_i &&
                      st_q == SQ_PLOAD && (got_main_q || got_spare_q);
  assign adr_ok     = adr_v && !busy_i && (st_q == SQ_PADDR || st_q == SQ_RADDR);
  assign last_adr   = adr_ok && adr_cnt_q == 2'd2;

  assign col_new = spare_q ? CW'(MAIN_BYTES) + CW'(data_i[SW-1:0]) : CW'(data_i);

  assign reg_clr_o  = op_load;
  assign reg_wr_o   = dat_v && !busy_i && st_q == SQ_PLOAD && col_q < CW'(PAGE_BYTES);
  assign reg_col_o  = col_q;
  assign reg_data_o = data_i;
  assign commit_o   = confirm_ok && ok_i;
  assign page_o     = page_q;
  assign use_main_o = got_main_q;
  assign use_spare_o = got_spare_q;
  assign rd_page_o  = page_q;
  assign rd_col_o   = ptr_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (op_rst) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = TW'(RST_CYCLES);
    end else if (confirm_ok) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = TW'(PROG_CYCLES);
    end else if (last_adr && st_q == SQ_RADDR) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = TW'(READ_CYCLES);
    end
  end

  always_comb begin
    sts                = 8'h00;
    sts[STS_READY_BIT] = !busy_i;
    sts[STS_FAIL_BIT]  = fail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      adr_cnt_q   <= '0;
      col_q       <= '0;
      ptr_q       <= '0;
      page_q      <= '0;
      spare_q     <= 1'b0;
      stat_q      <= 1'b0;
      fail_q      <= 1'b0;
      got_main_q  <= 1'b0;
      got_spare_q <= 1'b0;
    end else begin
      if (op_rst) begin
        st_q    <= SQ_IDLE;
        stat_q  <= 1'b0;
        spare_q <= 1'b0;
        fail_q  <= 1'b0;
      end else if (cmd_v && data_i == OP_STATUS) begin
        stat_q <= 1'b1;
      end else if (op_load) begin
        st_q        <= SQ_PADDR;
        adr_cnt_q   <= '0;
        stat_q      <= 1'b0;
        got_main_q  <= 1'b0;
        got_spare_q <= 1'b0;
      end else if (op_spare) begin
        st_q      <= SQ_RADDR;
        adr_cnt_q <= '0;
        stat_q    <= 1'b0;
        spare_q   <= 1'b1;
      end else if (confirm_ok) begin
        st_q   <= SQ_IDLE;
        stat_q <= 1'b0;
        fail_q <= !ok_i;
      end else if (adr_ok) begin
        adr_cnt_q <= adr_cnt_q + 1'b1;
        if (adr_cnt_q == 2'd0) col_q  <= col_new;
        if (adr_cnt_q == 2'd1) page_q <= data_i[PW-1:0];
        if (last_adr) begin
          if (st_q == SQ_PADDR) begin
            st_q <= SQ_PLOAD;
          end else begin
            st_q  <= SQ_RDATA;
            ptr_q <= col_q;
          end
        end
      end else if (reg_wr_o) begin
        col_q <= col_q + 1'b1;
        if (col_q < CW'(MAIN_BYTES)) got_main_q  <= 1'b1;
        else                         got_spare_q <= 1'b1;
      end

      if (rd_stb_i && !stat_q && st_q == SQ_RDATA && !busy_i && ptr_q < CW'(PAGE_BYTES))
        ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= 8'h00;
    end else if (rd_stb_i) begin
      if (stat_q)
        dout_q <= sts;
      else if (st_q == SQ_RDATA && !busy_i && ptr_q < CW'(PAGE_BYTES))
        dout_q <= rd_data_i;
      else
        dout_q <= 8'hFF;
    end
  end

  assign data_o = dout_q;

  AST_CONFIRM_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_v && data_i == OP_CONFIRM && !busy_i && st_q != SQ_PLOAD) |=> !busy_i); // R2
  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !op_rst && !(cmd_v && data_i == OP_STATUS))
      |=> ($stable(st_q) && $stable(col_q) && $stable(spare_q))); // R3
  AST_STATUS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && rd_stb_i) |=> (data_o[STS_READY_BIT] == !$past(busy_i))); // R4
  AST_STATUS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !cmd_v) |=> stat_q); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_rst |=> (!stat_q && !fail_q && busy_i)); // R10
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if #(
  parameter int NUM_PAGES    = 2,
  parameter int MAIN_BYTES   = 512,
  parameter int SPARE_BYTES  = 16,
  parameter int MAIN_PP_MAX  = 2,
  parameter int SPARE_PP_MAX = 3,
  parameter int TW           = 16,
  parameter int PROG_CYCLES  = 1000,
  parameter int READ_CYCLES  = 50,
  parameter int RST_CYCLES   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stb_i,
  input  logic       cmd_latch_i,
  input  logic       addr_latch_i,
  input  logic [7:0] data_i,
  input  logic       rd_stb_i,
  output logic [7:0] data_o,
  output logic       busy_o
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int CW         = $clog2(PAGE_BYTES + 1);
  localparam int PW         = $clog2(NUM_PAGES);
  localparam int SW         = $clog2(SPARE_BYTES);

  logic          reg_clr, reg_wr, commit, use_main, use_spare, ok, tmr_load;
  logic [CW-1:0] reg_col, rd_col;
  logic [7:0]    reg_data, rd_data;
  logic [PW-1:0] page, rd_page;
  logic [TW-1:0] tmr_val;

  nand_cmd_seq #(
    .MAIN_BYTES(MAIN_BYTES), .PAGE_BYTES(PAGE_BYTES), .CW(CW), .PW(PW), .SW(SW),
    .TW(TW), .PROG_CYCLES(PROG_CYCLES), .READ_CYCLES(READ_CYCLES), .RST_CYCLES(RST_CYCLES)
  ) u_seq (
    .clk_i, .rst_ni, .wr_stb_i, .cmd_latch_i, .addr_latch_i, .data_i, .rd_stb_i,
    .busy_i(busy_o), .ok_i(ok), .rd_data_i(rd_data),
    .reg_clr_o(reg_clr), .reg_wr_o(reg_wr), .reg_col_o(reg_col), .reg_data_o(reg_data),
    .commit_o(commit), .page_o(page), .use_main_o(use_main), .use_spare_o(use_spare),
    .rd_page_o(rd_page), .rd_col_o(rd_col), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .data_o(data_o)
  );

  nand_page_store #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .CW(CW), .PW(PW)
  ) u_store (
    .clk_i, .rst_ni, .clr_i(reg_clr), .wr_i(reg_wr), .wr_col_i(reg_col),
    .wr_data_i(reg_data), .commit_i(commit), .page_i(page), .rd_page_i(rd_page),
    .rd_col_i(rd_col), .rd_data_o(rd_data)
  );

  nand_pp_limit #(
    .NUM_PAGES(NUM_PAGES), .PW(PW), .MAIN_PP_MAX(MAIN_PP_MAX), .SPARE_PP_MAX(SPARE_PP_MAX)
  ) u_limit (
    .clk_i, .rst_ni, .page_i(page), .use_main_i(use_main), .use_spare_i(use_spare),
    .commit_i(commit), .ok_o(ok)
  );

  nand_busy_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .busy_o(busy_o)
  );
endmodule

// File: tb/nand_cmd_if_test.sv
`timescale 1ns/1ps
module nand_cmd_if_test;
  localparam logic [3:0] K_CMD = 4'd0, K_DAT = 4'd1, K_PGM = 4'd2, K_RSP = 4'd3,
                         K_RD  = 4'd4, K_BSY = 4'd5, K_WAIT = 4'd6;
  localparam int NV = 52;
  // {kind, value/expected, aux (page), requirement number}
  localparam logic [23:0] VEC [NV] = '{
    {K_CMD, 8'h70, 8'h00, 4'd4}, {K_RD, 8'h40, 8'h00, 4'd4},        // R4
    {K_RD,  8'h40, 8'h00, 4'd5},                                     // R5
    {K_CMD, 8'h10, 8'h00, 4'd2}, {K_BSY, 8'h00, 8'h00, 4'd2},        // R2
    {K_PGM, 8'h00, 8'h00, 4'd2}, {K_CMD, 8'h10, 8'h00, 4'd2},
    {K_BSY, 8'h00, 8'h00, 4'd2},                                     // R2 no data
    {K_RSP, 8'h03, 8'h00, 4'd8}, {K_BSY, 8'h01, 8'h00, 4'd8},        // R8
    {K_WAIT,8'h00, 8'h00, 4'd8}, {K_RD, 8'hFF, 8'h00, 4'd8},
    {K_PGM, 8'h12, 8'h00, 4'd1}, {K_DAT, 8'hA5, 8'h00, 4'd1},        // R1 spare col 2
    {K_DAT, 8'h3C, 8'h00, 4'd1}, {K_CMD, 8'h10, 8'h00, 4'd6},
    {K_BSY, 8'h01, 8'h00, 4'd6},                                     // R6
    {K_CMD, 8'h70, 8'h00, 4'd4}, {K_RD, 8'h00, 8'h00, 4'd4},
    {K_CMD, 8'h50, 8'h00, 4'd3},                                     // R3 ignored while busy
    {K_WAIT,8'h00, 8'h00, 4'd3}, {K_RD, 8'h40, 8'h00, 4'd3},
    {K_RSP, 8'h02, 8'h00, 4'd8}, {K_WAIT,8'h00, 8'h00, 4'd8},
    {K_RD,  8'hA5, 8'h00, 4'd8}, {K_RD, 8'h3C, 8'h00, 4'd1},
    {K_RD,  8'hFF, 8'h00, 4'd1},
    {K_PGM, 8'h02, 8'h00, 4'd7}, {K_DAT, 8'hF0, 8'h00, 4'd7},        // R7
    {K_CMD, 8'h10, 8'h00, 4'd7}, {K_WAIT,8'h00, 8'h00, 4'd7},
    {K_CMD, 8'h70, 8'h00, 4'd7}, {K_RD, 8'h40, 8'h00, 4'd7},
    {K_RSP, 8'h02, 8'h00, 4'd7}, {K_WAIT,8'h00, 8'h00, 4'd7},
    {K_RD,  8'hA0, 8'h00, 4'd7},
    {K_PGM, 8'h0F, 8'h00, 4'd9}, {K_DAT, 8'h7E, 8'h00, 4'd9},        // R9 third spare
    {K_CMD, 8'h10, 8'h00, 4'd9}, {K_WAIT,8'h00, 8'h00, 4'd9},
    {K_PGM, 8'h0E, 8'h00, 4'd9}, {K_DAT, 8'h00, 8'h00, 4'd9},        // fourth spare
    {K_CMD, 8'h10, 8'h00, 4'd9}, {K_WAIT,8'h00, 8'h00, 4'd9},
    {K_CMD, 8'h70, 8'h00, 4'd9}, {K_RD, 8'h41, 8'h00, 4'd9},
    {K_RSP, 8'h0E, 8'h00, 4'd9}, {K_WAIT,8'h00, 8'h00, 4'd9},
    {K_RD,  8'hFF, 8'h00, 4'd9}, {K_RD, 8'h7E, 8'h00, 4'd9},
    {K_RD,  8'hFF, 8'h00, 4'd8},                                     // R8 past end
    {K_CMD, 8'hFF, 8'h00, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_stb = 1'b0, cmd_latch = 1'b0, addr_latch = 1'b0, rd_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] data_o;
  logic       busy_o;
  int         nchk = 0, nfail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  nand_cmd_if #(
    .NUM_PAGES(2), .PROG_CYCLES(20), .READ_CYCLES(5), .RST_CYCLES(3)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .cmd_latch_i(cmd_latch),
    .addr_latch_i(addr_latch), .data_i(wdata), .rd_stb_i(rd_stb),
    .data_o(data_o), .busy_o(busy_o)
  );

  function automatic string rtag(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int r);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h at %0t", rtag(r), act, exp, $time);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; cmd_latch = c; addr_latch = a; wdata = d;
    @(negedge clk);
    wr_stb = 1'b0; cmd_latch = 1'b0; addr_latch = 1'b0;
  endtask

  task automatic run_vec(input logic [3:0] k, input logic [7:0] v, input logic [7:0] a, input int r);
    case (k)
      K_CMD: bus(1'b1, 1'b0, v);
      K_DAT: bus(1'b0, 1'b0, v);
      K_PGM, K_RSP: begin
        bus(1'b1, 1'b0, (k == K_PGM) ? 8'h80 : 8'h50);
        bus(1'b0, 1'b1, v);
        bus(1'b0, 1'b1, a);
        bus(1'b0, 1'b1, 8'h00);
      end
      K_RD: begin
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        check(data_o, v, r);
      end
      K_BSY: check({7'b0, busy_o}, v, r);
      K_WAIT: begin
        for (int n = 0; n < 2000 && busy_o; n++) @(negedge clk);
      end
      default: ;
    endcase
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({7'b0, busy_o}, 8'h00, 11);  // R11 reset state
    check(data_o, 8'h00, 11);          // R11
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][23:20], VEC[i][19:12], VEC[i][11:4], int'(VEC[i][3:0]));
    run_vec(K_WAIT, 8'h00, 8'h00, 10);

    // R9: main budget on page 1, spare budget on the same page still free
    for (int p = 0; p < 3; p++) begin
      run_vec(K_PGM, 8'h00, 8'h01, 9);
      run_vec(K_DAT, 8'h11, 8'h00, 9);
      run_vec(K_CMD, 8'h10, 8'h00, 9);
      run_vec(K_WAIT, 8'h00, 8'h00, 9);
      run_vec(K_CMD, 8'h70, 8'h00, 9);
      run_vec(K_RD, (p == 2) ? 8'h41 : 8'h40, 8'h00, 9);
    end
    run_vec(K_RSP, 8'h00, 8'h01, 9);
    run_vec(K_WAIT, 8'h00, 8'h00, 9);
    run_vec(K_PGM, 8'h00, 8'h01, 9);
    run_vec(K_DAT, 8'h5A, 8'h00, 9);
    run_vec(K_CMD, 8'h10, 8'h00, 9);
    run_vec(K_WAIT, 8'h00, 8'h00, 9);
    run_vec(K_CMD, 8'h70, 8'h00, 9);
    run_vec(K_RD, 8'h40, 8'h00, 9);
    run_vec(K_RSP, 8'h00, 8'h01, 9);
    run_vec(K_WAIT, 8'h00, 8'h00, 9);
    run_vec(K_RD, 8'h5A, 8'h00, 9);

    // R10: reset cuts a program short and clears status mode/fail
    run_vec(K_CMD, 8'hFF, 8'h00, 10);
    run_vec(K_WAIT, 8'h00, 8'h00, 10);
    run_vec(K_PGM, 8'h01, 8'h00, 10);
    run_vec(K_DAT, 8'h00, 8'h00, 10);
    run_vec(K_CMD, 8'h10, 8'h00, 10);
    run_vec(K_BSY, 8'h01, 8'h00, 10);
    run_vec(K_CMD, 8'hFF, 8'h00, 10);
    repeat (4) @(negedge clk);
    check({7'b0, busy_o}, 8'h00, 10);
    run_vec(K_CMD, 8'h70, 8'h00, 10);
    run_vec(K_RD, 8'h40, 8'h00, 10);

    // R10: reset aborts a pending load, so a later confirm is dropped
    run_vec(K_PGM, 8'h00, 8'h00, 10);
    run_vec(K_DAT, 8'h00, 8'h00, 10);
    run_vec(K_CMD, 8'hFF, 8'h00, 10);
    run_vec(K_WAIT, 8'h00, 8'h00, 10);
    run_vec(K_CMD, 8'h10, 8'h00, 10);
    run_vec(K_BSY, 8'h00, 8'h00, 10);

    // R11: asynchronous reset during a read erases the array
    run_vec(K_RSP, 8'h02, 8'h00, 11);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    check({7'b0, busy_o}, 8'h00, 11);
    check(data_o, 8'h00, 11);
    rst_ni = 1'b1;
    run_vec(K_RSP, 8'h02, 8'h00, 11);
    run_vec(K_WAIT, 8'h00, 8'h00, 11);
    run_vec(K_RD, 8'hFF, 8'h00, 11);

    finish_run();
  end
endmodule